// File: doc/BRIEF.md
# Scan Chain with Data-Flow Intrusion Sensing

This block is a mux-D scan chain over a register of functional flip-flops. Extra sensing flip-flops are placed at fixed intervals along the chain. Each sensing cell reloads a constant in functional operation, so it never changes while the chip runs normally. When scan shifting is forced, for example by probing the shift-enable net, data from the previous cell moves into the sensing cells. Any sensing cell that then holds a value other than its constant reports a hit.

There are two sensing polarities. Cells tied to 1 report a 0 passing through, and cells tied to 0 report a 1. The two kinds alternate along the chain, so a shifted stream is caught whichever values it carries.

A small guard watches all hits together with a permission flag from the test controller. If a hit appears while shifting is not permitted, the guard sets a sticky alarm. The alarm drives a chip reset request and holds until the asynchronous reset clears it.

Top module: `spy_scan_chain`

## Requirements
- R1: While rstN is low and just after it is released, funcQ is all zeros, every sensing cell holds its tie value, spyHit0 and spyHit1 are all zero, and alarm and resetReq are 0.
- R2: With scanEn low, each clock edge loads funcD into funcQ and reloads every sensing cell with its tie value, so both hit vectors read zero after that edge.
- R3: With scanEn high, each clock edge moves every chain cell to the next position and loads scanIn into position 0. scanOut is the last position. The chain length is FUNC_W+2*SPY_N.
- R4: The chain has 2*SPY_N sensing slots. With STRIDE=(FUNC_W+2*SPY_N)/(2*SPY_N), slot k sits at position (k+1)*STRIDE-1. An even slot k is tied to 1 and drives spyHit0[k/2] high while it holds 0. An odd slot k is tied to 0 and drives spyHit1[k/2] high while it holds 1.
- R5: A shift that delivers to every sensing slot a value equal to its tie value raises no hit and no alarm.
- R6: If any hit bit is high while testOk is low, alarm is 1 after the next clock edge. Alarm then stays 1 until rstN goes low.
- R7: While testOk is high, hits do not set the alarm, so a permitted scan shift leaves alarm at 0.
- R8: resetReq always equals alarm.
- R9: funcQ[j] is the j-th chain position that is not a sensing slot, counted from the scanIn end. In functional capture it loads funcD[j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| scanEn | input | 1 | Shift enable for the whole chain |
| scanIn | input | 1 | Serial data into chain position 0 |
| funcD | input | FUNC_W | Functional data for the ordinary cells |
| testOk | input | 1 | Test controller permits shifting |
| scanOut | output | 1 | Last chain position |
| funcQ | output | FUNC_W | Contents of the ordinary cells |
| spyHit0 | output | SPY_N | Hits from cells tied to 1 |
| spyHit1 | output | SPY_N | Hits from cells tied to 0 |
| alarm | output | 1 | Sticky intrusion flag |
| resetReq | output | 1 | Chip reset request |

## Verification
The bench builds the block with FUNC_W=10 and SPY_N=3. That gives a 16-cell chain with a stride of 2, so the six sensing cells sit at the odd positions 1 to 11 and alternate in polarity. Every slot is then inside the chain and next to an ordinary cell. A single shift can therefore hit or spare each slot depending on the functional word loaded just before it, which is how the data-dependent miss and the alarm path are both reached in a few cycles. A full 16-bit pass also pushes every sensing cell out through scanOut under permission.

// File: rtl/spy_scan_pkg.sv
package spy_scan_pkg;

  typedef struct packed {
    logic shift;
    logic capture;
  } cellStrobe_t;

  function automatic int spyStride(int funcW, int spyN);
    return (funcW + 2 * spyN) / (2 * spyN);
  endfunction

  // slot number of a chain position, or -1 for an ordinary cell
  function automatic int slotOf(int pos, int funcW, int spyN);
    int stride;
    stride = spyStride(funcW, spyN);
    if (((pos + 1) % stride) == 0 && ((pos + 1) / stride) <= 2 * spyN)
      return (pos + 1) / stride - 1;
    return -1;
  endfunction

  // index into the functional word of an ordinary cell
  function automatic int funcIdxOf(int pos, int funcW, int spyN);
    int n;
    n = 0;
    for (int p = 0; p < pos; p++)
      if (slotOf(p, funcW, spyN) < 0) n++;
    return n;
  endfunction

endpackage

// File: rtl/spy_chain_dp.sv
module spy_chain_dp
  import spy_scan_pkg::*;
#(
  parameter int FUNC_W = 12,
  parameter int SPY_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellStrobe_t       strobes,
  input  logic              scanIn,
  input  logic [FUNC_W-1:0] funcD,
  output logic              scanOut,
  output logic [FUNC_W-1:0] funcQ,
  output logic [SPY_N-1:0]  spyHit0,
  output logic [SPY_N-1:0]  spyHit1
);
  localparam int TOTAL = FUNC_W + 2 * SPY_N;

  logic [TOTAL-1:0] chainQ;

  for (genvar i = 0; i < TOTAL; i++) begin : g_cell
    localparam int SLOT = slotOf(i, FUNC_W, SPY_N);
    logic prevQ;
    logic cellQ;

    if (i == 0) begin : g_head
      assign prevQ = scanIn;
    end else begin : g_link
      assign prevQ = chainQ[i-1];
    end

    if (SLOT < 0) begin : g_func
      localparam int FI = funcIdxOf(i, FUNC_W, SPY_N);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                cellQ <= 1'b0;
        else if (strobes.shift)   cellQ <= prevQ;
        else if (strobes.capture) cellQ <= funcD[FI];
      end
      assign funcQ[FI] = cellQ;
    end else begin : g_spy
      localparam logic TIE = ((SLOT % 2) == 0) ? 1'b1 : 1'b0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                cellQ <= TIE;
        else if (strobes.shift)   cellQ <= prevQ;
        else if (strobes.capture) cellQ <= TIE;
      end
      if (TIE) begin : g_low
        assign spyHit0[SLOT/2] = ~cellQ;
      end else begin : g_high
        assign spyHit1[SLOT/2] = cellQ;
      end
    end

    assign chainQ[i] = cellQ;
  end

  assign scanOut = chainQ[TOTAL-1];

  // R3: serial input enters position 0 and the rest move along
  a_r3_head: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> chainQ[0] == $past(scanIn));
  a_r3_move: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> chainQ[TOTAL-1:1] == $past(chainQ[TOTAL-2:0]));
  // R2: a capture cycle returns every sensing cell to rest
  a_r2_settle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (spyHit0 == '0 && spyHit1 == '0));

endmodule

// File: rtl/spy_guard_ctrl.sv
module spy_guard_ctrl
  import spy_scan_pkg::*;
#(
  parameter int SPY_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanEn,
  input  logic             testOk,
  input  logic [SPY_N-1:0] spyHit0,
  input  logic [SPY_N-1:0] spyHit1,
  output cellStrobe_t      strobes,
  output logic             alarm
);
  logic anyHit;
  logic intrusion;

  always_comb begin
    strobes.shift   = scanEn;
    strobes.capture = ~scanEn;
  end

  assign anyHit    = (|spyHit0) | (|spyHit1);
  assign intrusion = anyHit & ~testOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          alarm <= 1'b0;
    else if (intrusion) alarm <= 1'b1;
  end

  // R6: a hit without permission sets the alarm, which then holds
  a_r6_set: assert property (@(posedge clk) disable iff (!rstN)
    ((|spyHit0 || |spyHit1) && !testOk) |=> alarm);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    alarm |=> alarm);
  // R7: with permission a quiet alarm stays quiet
  a_r7_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!alarm && testOk) |=> !alarm);

endmodule

// File: rtl/spy_scan_chain.sv
module spy_scan_chain
  import spy_scan_pkg::*;
#(
  parameter int FUNC_W = 12,
  parameter int SPY_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanEn,
  input  logic              scanIn,
  input  logic [FUNC_W-1:0] funcD,
  input  logic              testOk,
  output logic              scanOut,
  output logic [FUNC_W-1:0] funcQ,
  output logic [SPY_N-1:0]  spyHit0,
  output logic [SPY_N-1:0]  spyHit1,
  output logic              alarm,
  output logic              resetReq
);
  cellStrobe_t strobes;

  spy_guard_ctrl #(.SPY_N(SPY_N)) ctrl_i (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .testOk(testOk),
    .spyHit0(spyHit0), .spyHit1(spyHit1), .strobes(strobes), .alarm(alarm)
  );

  spy_chain_dp #(.FUNC_W(FUNC_W), .SPY_N(SPY_N)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .scanIn(scanIn),
    .funcD(funcD), .scanOut(scanOut), .funcQ(funcQ),
    .spyHit0(spyHit0), .spyHit1(spyHit1)
  );

  // R8: the reset request mirrors the alarm
  assign resetReq = alarm;

endmodule

// File: tb/spy_scan_chain_tb_top.sv
`timescale 1ns/1ps
module spy_scan_chain_tb_top;
  localparam int FW = 10;
  localparam int SN = 3;
  localparam int TOT = FW + 2 * SN;
  localparam int STRIDE = TOT / (2 * SN);

  typedef struct packed {
    logic          so;
    logic [FW-1:0] fq;
    logic [SN-1:0] h0;
    logic [SN-1:0] h1;
    logic          al;
    logic          rr;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanEn = 1'b0, scanIn = 1'b0, testOk = 1'b0;
  logic [FW-1:0] funcD = '0;
  logic scanOut, alarm, resetReq;
  logic [FW-1:0] funcQ;
  logic [SN-1:0] spyHit0, spyHit1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t  expQ[$];
  string tagQ[$];

  logic m[TOT];
  logic alarmM;

  always #2.5 clk = ~clk;

  spy_scan_chain #(.FUNC_W(FW), .SPY_N(SN)) dut_i (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn),
    .funcD(funcD), .testOk(testOk), .scanOut(scanOut), .funcQ(funcQ),
    .spyHit0(spyHit0), .spyHit1(spyHit1), .alarm(alarm), .resetReq(resetReq)
  );

  // slot of a position per R4, -1 for an ordinary cell
  function automatic int slotAt(int p);
    if (((p + 1) % STRIDE) == 0 && ((p + 1) / STRIDE) <= 2 * SN)
      return (p + 1) / STRIDE - 1;
    return -1;
  endfunction

  function automatic logic tieOf(int slot);
    return (slot % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic exp_t modelOut();
    exp_t e;
    int fi;
    fi = 0;
    e = '0;
    for (int p = 0; p < TOT; p++) begin
      int s;
      s = slotAt(p);
      if (s < 0) begin
        e.fq[fi] = m[p];
        fi++;
      end else if (tieOf(s)) e.h0[s/2] = ~m[p];
      else e.h1[s/2] = m[p];
    end
    e.so = m[TOT-1];
    e.al = alarmM;
    e.rr = alarmM;
    return e;
  endfunction

  task automatic modelReset();
    for (int p = 0; p < TOT; p++) begin
      int s;
      s = slotAt(p);
      m[p] = (s < 0) ? 1'b0 : tieOf(s);
    end
    alarmM = 1'b0;
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic step(logic se, logic si, logic [FW-1:0] fd, logic ok, string tag);
    exp_t pre;
    @(negedge clk);
    scanEn = se; scanIn = si; funcD = fd; testOk = ok;
    pre = modelOut();
    if (((|pre.h0) || (|pre.h1)) && !ok) alarmM = 1'b1;
    if (se) begin
      for (int p = TOT - 1; p > 0; p--) m[p] = m[p-1];
      m[0] = si;
    end else begin
      int fi;
      fi = 0;
      for (int p = 0; p < TOT; p++) begin
        int s;
        s = slotAt(p);
        if (s < 0) begin
          m[p] = fd[fi];
          fi++;
        end else m[p] = tieOf(s);
      end
    end
    expQ.push_back(modelOut());
    tagQ.push_back(tag);
  endtask

  // monitor: compare after every edge that has a queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " chain"}, {21'b0, scanOut, funcQ}, {21'b0, e.so, e.fq});
        check({t, " hits"}, {26'b0, spyHit0, spyHit1}, {26'b0, e.h0, e.h1});
        check({t, " alarm R6 R8"}, {30'b0, alarm, resetReq}, {30'b0, e.al, e.rr});
      end
    end
  end

  task automatic resetCheck(string tag);
    check({tag, " R1 funcQ"}, {22'b0, funcQ}, 32'h0);
    check({tag, " R1 hits"}, {26'b0, spyHit0, spyHit1}, 32'h0);
    check({tag, " R1 alarm"}, {30'b0, alarm, resetReq}, 32'h0);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    resetCheck("in reset");
    rstN = 1'b1;
    @(negedge clk);
    resetCheck("after release");

    // R2 R9 functional capture, no permission
    step(0, 0, 10'h2A5, 0, "R2 R9 cap a");
    step(0, 0, 10'h15A, 0, "R2 R9 cap b");
    step(0, 0, 10'h3FF, 0, "R2 R9 cap c");
    step(0, 0, 10'h001, 0, "R2 R9 cap d");

    // R3 R4 R7 permitted full pass
    for (int k = 0; k < TOT; k++)
      step(1, k[0] ^ k[2], 10'h0, 1, "R3 R4 R7 shift");
    step(0, 0, 10'h0C3, 1, "R2 R7 restore");

    // R5 miss: every slot receives its tie value
    step(0, 0, 10'h015, 0, "R5 load");
    step(1, 0, 10'h0, 0, "R5 shift");
    step(0, 0, 10'h0, 0, "R5 no alarm");

    // R6 hit: slot 0 receives 0
    step(1, 1, 10'h0, 0, "R4 R6 shift hit");
    step(0, 0, 10'h0, 0, "R6 alarm set");
    step(0, 0, 10'h155, 1, "R6 sticky");
    step(1, 1, 10'h0, 1, "R6 sticky shift");
    step(0, 0, 10'h0, 0, "R6 sticky cap");

    // R6 clear by reset
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b0;
    modelReset();
    #1;
    resetCheck("R6 clear");
    @(negedge clk);
    rstN = 1'b1;

    // R4 polarity of the high-sensing slots under permission
    step(0, 0, 10'h3FF, 1, "R4 load ones");
    step(1, 1, 10'h0, 1, "R4 R7 odd slots");
    step(0, 0, 10'h0, 0, "R7 still quiet");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule